// File: doc/BRIEF.md
# Filtered Comparator Interrupt Controller

This block turns the one-bit result of an analog comparator into a maskable, software-cleared interrupt. Software controls it through one 8-bit control byte on a simple register bus. The comparator result can be used raw, or it can first pass through a digital noise filter. The filter samples the comparator on divided rising edges of a low-speed clock. A level is accepted only after it has been seen on three samples in a row.

An edge detector watches the selected signal, either rising or falling as software chooses. When the chosen edge occurs, it latches an interrupt flag. The flag is raised only while the interrupt is enabled and the comparator is powered. Software clears the flag by writing zero to it.

A live monitor bit shows the comparator state, and it reads 1 while the comparator is off. Writes reach the register only while a separate unlock input is high. Changing the filter mode or the sampling divider restarts the filter from the current monitor value, so that the switch cannot create a false edge.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: After reset, with the comparator disabled, the control byte reads 8'h8A and `irq` is 0.
- R2: A write changes the register only when `bus_wr` is 1, `bus_addr` equals `REG_ADDR` and `wr_unlock` is 1. Any other write leaves the read-back value unchanged.
- R3: Bit 6 always reads 0. Bit 3 is read-only: writing it has no effect on the read-back value.
- R4: Bit 3 reads `cmp_out` while `cmp_en` is 1, and reads 1 while `cmp_en` is 0.
- R5: With bit 1 = 1 (bypass), a qualifying change of `cmp_out` sets the flag (bit 2) at the first rising clock edge after the change.
- R6: Bit 7 = 0 triggers on a 0-to-1 change of the selected signal. Bit 7 = 1 triggers on a 1-to-0 change. The opposite change never sets the flag.
- R7: With bit 1 = 0, the selected signal takes a new level only after that level has been sampled on 3 consecutive sample ticks. A sample tick is every N-th rising edge of `slow_clk`, with N = 1, 2, 4 or 8 for bits 5:4 = 00, 01, 10 or 11.
- R8: Writing 0 to bit 2 clears the flag, and writing 1 leaves it unchanged. If a hardware set and a clearing write fall in the same cycle, the flag ends up 1.
- R9: The flag is set only while bit 0 = 1 and `cmp_en` = 1. `irq` is 1 exactly when the flag, bit 0 and `cmp_en` are all 1.
- R10: A write that changes bit 1 or bits 5:4 reloads the filter with the current monitor value. It raises no flag unless the signal changes afterwards.
- R11: A sample that differs from the current run restarts the count, so a run broken by one opposite sample does not update the filtered level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; combinational, 0 when not selected |
| wr_unlock | input | 1 | Write-protect release; writes are dropped while 0 |
| cmp_out | input | 1 | Comparator result, synchronous to `clk` |
| cmp_en | input | 1 | Comparator circuit powered |
| slow_clk | input | 1 | Low-speed sampling clock, sampled in the `clk` domain |
| irq | output | 1 | Interrupt request |

## Verification
Read-back and `irq` are combinational from the register and inputs, so the bench samples them between edges, right after the edge that commits a write. In bypass mode the flag appears one edge after `cmp_out` changes. In filter mode, a `slow_clk` rise that is high at a clock edge counts at that edge, the filtered level moves at the edge of the 3N-th counted rise, and the flag follows one edge later. For each divider setting the bench checks the flag one rise early (still 0) and one edge after the last rise (now 1), so a shift of one tick in either direction is reported.

// File: rtl/cmp_irq_pkg.sv
`timescale 1ns/1ps
package cmp_irq_pkg;

    localparam int REG_W      = 8;
    localparam int DIV_SEL_W  = 2;

    localparam int BIT_IE     = 0;
    localparam int BIT_BYP    = 1;
    localparam int BIT_FLAG   = 2;
    localparam int BIT_MON    = 3;
    localparam int BIT_DIV_LO = 4;
    localparam int BIT_DIV_HI = BIT_DIV_LO + DIV_SEL_W - 1;
    localparam int BIT_RSV    = 6;
    localparam int BIT_EDGE   = 7;

    typedef struct packed {
        logic                 edge_fall;
        logic [DIV_SEL_W-1:0] div_sel;
        logic                 flag;
        logic                 bypass;
        logic                 irq_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        edge_fall: 1'b1,
        div_sel:   '0,
        flag:      1'b0,
        bypass:    1'b1,
        irq_en:    1'b0
    };

endpackage

// File: rtl/cmp_tick_div.sv
`timescale 1ns/1ps
module cmp_tick_div #(
    parameter int DIV_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slow_clk,
    input  logic                 reload,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 samp_tick
);
    localparam int MAX_SHIFT = (1 << DIV_SEL_W) - 1;
    localparam int CNT_W     = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

    typedef struct packed {
        logic             slow;
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t st_q, st_d;
    logic             rise;
    logic [CNT_W-1:0] last;

    always_comb begin
        st_d      = st_q;
        st_d.slow = slow_clk;
        rise      = slow_clk && !st_q.slow;
        last      = CNT_W'((1 << div_sel) - 1);
        samp_tick = rise && (st_q.cnt == last) && !reload;
        if (reload) begin
            st_d.cnt = '0;
        end else if (rise) begin
            st_d.cnt = (st_q.cnt == last) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cmp_glitch_filter.sv
`timescale 1ns/1ps
module cmp_glitch_filter #(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic reload,
    input  logic din,
    output logic dout
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);

    typedef struct packed {
        logic             cand;
        logic [RUN_W-1:0] run;
        logic             level;
    } filt_st_t;

    filt_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (reload) begin
            st_d.cand  = din;
            st_d.run   = '0;
            st_d.level = din;
        end else if (sample) begin
            if (din == st_q.cand) begin
                st_d.run = (st_q.run == RUN_MAX) ? st_q.run : st_q.run + 1'b1;
            end else begin
                st_d.cand = din;
                st_d.run  = RUN_W'(1);
            end
            if (st_d.run == RUN_MAX) begin
                st_d.level = st_d.cand;
            end
        end
    end

    assign dout = st_q.level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cand: 1'b1, run: '0, level: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cmp_edge_det.sv
`timescale 1ns/1ps
module cmp_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic reload,
    input  logic reload_val,
    input  logic fall_sel,
    output logic hit
);
    logic prev_q, prev_d;

    always_comb begin
        prev_d = reload ? reload_val : sig;
        if (reload) begin
            hit = 1'b0;
        end else if (fall_sel) begin
            hit = prev_q && !sig;
        end else begin
            hit = sig && !prev_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/cmp_irq_ctrl.sv
`timescale 1ns/1ps
module cmp_irq_ctrl
    import cmp_irq_pkg::*;
#(
    parameter int          ADDR_W   = 6,
    parameter int unsigned REG_ADDR = 12,
    parameter int          RUN_LEN  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              wr_unlock,
    input  logic              cmp_out,
    input  logic              cmp_en,
    input  logic              slow_clk,
    output logic              irq
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  init;
    } top_st_t;

    top_st_t st_q, st_d;

    logic addr_hit, wr_ok, clr_req, cfg_chg, reload;
    logic mon, samp_tick, filt_level, sel_sig, edge_hit, hw_set;

    assign mon = cmp_en ? cmp_out : 1'b1;

    cmp_tick_div #(.DIV_SEL_W(DIV_SEL_W)) div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_clk  (slow_clk),
        .reload    (reload),
        .div_sel   (st_q.ctrl.div_sel),
        .samp_tick (samp_tick)
    );

    cmp_glitch_filter #(.RUN_LEN(RUN_LEN)) filt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (samp_tick),
        .reload (reload),
        .din    (mon),
        .dout   (filt_level)
    );

    cmp_edge_det edge_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig        (sel_sig),
        .reload     (reload),
        .reload_val (mon),
        .fall_sel   (st_q.ctrl.edge_fall),
        .hit        (edge_hit)
    );

    always_comb begin
        addr_hit = (bus_addr == ADDR_W'(REG_ADDR));
        wr_ok    = bus_wr && addr_hit && wr_unlock;
        clr_req  = wr_ok && !bus_wdata[BIT_FLAG];
        cfg_chg  = wr_ok &&
                   ((bus_wdata[BIT_BYP] != st_q.ctrl.bypass) ||
                    (bus_wdata[BIT_DIV_HI:BIT_DIV_LO] != st_q.ctrl.div_sel));
        reload   = st_q.init || cfg_chg;
        sel_sig  = st_q.ctrl.bypass ? mon : filt_level;
        hw_set   = edge_hit && st_q.ctrl.irq_en && cmp_en;

        st_d      = st_q;
        st_d.init = 1'b0;
        if (wr_ok) begin
            st_d.ctrl.irq_en    = bus_wdata[BIT_IE];
            st_d.ctrl.bypass    = bus_wdata[BIT_BYP];
            st_d.ctrl.div_sel   = bus_wdata[BIT_DIV_HI:BIT_DIV_LO];
            st_d.ctrl.edge_fall = bus_wdata[BIT_EDGE];
        end
        if (clr_req) begin
            st_d.ctrl.flag = 1'b0;
        end
        if (hw_set) begin
            st_d.ctrl.flag = 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && addr_hit) begin
            bus_rdata[BIT_IE]                = st_q.ctrl.irq_en;
            bus_rdata[BIT_BYP]               = st_q.ctrl.bypass;
            bus_rdata[BIT_FLAG]              = st_q.ctrl.flag;
            bus_rdata[BIT_MON]               = mon;
            bus_rdata[BIT_DIV_HI:BIT_DIV_LO] = st_q.ctrl.div_sel;
            bus_rdata[BIT_RSV]               = 1'b0;
            bus_rdata[BIT_EDGE]              = st_q.ctrl.edge_fall;
        end
    end

    assign irq = st_q.ctrl.flag && st_q.ctrl.irq_en && cmp_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ctrl: CTRL_RST, init: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cmp_irq_ctrl_chk.sv
`timescale 1ns/1ps
module cmp_irq_ctrl_chk
    import cmp_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic             addr_hit,
    input logic             wr_unlock,
    input logic [REG_W-1:0] bus_wdata,
    input logic [REG_W-1:0] bus_rdata,
    input logic             cmp_en,
    input logic             irq,
    input ctrl_t            ctrl,
    input logic             hw_set,
    input logic             samp_tick,
    input logic             reload,
    input logic             filt_level
);
    assert_irq_off_when_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |-> !irq);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.flag && !(bus_wr && addr_hit && wr_unlock && !bus_wdata[BIT_FLAG])) |=> ctrl.flag);

    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> ctrl.flag);

    assert_locked_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && addr_hit && wr_unlock) |=>
            ($stable(ctrl.irq_en) && $stable(ctrl.bypass) &&
             $stable(ctrl.div_sel) && $stable(ctrl.edge_fall)));

    assert_rsvd_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BIT_RSV] == 1'b0);

    assert_monitor_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && addr_hit && !cmp_en) |-> bus_rdata[BIT_MON]);

    assert_filter_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!samp_tick && !reload) |=> $stable(filt_level));

    assert_no_set_on_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reload |-> !hw_set);
endmodule

bind cmp_irq_ctrl cmp_irq_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .addr_hit   (addr_hit),
    .wr_unlock  (wr_unlock),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cmp_en     (cmp_en),
    .irq        (irq),
    .ctrl       (st_q.ctrl),
    .hw_set     (hw_set),
    .samp_tick  (samp_tick),
    .reload     (reload),
    .filt_level (filt_level)
);

// File: tb/cmp_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module cmp_irq_ctrl_tb_top;
    localparam int ADDR_W   = 6;
    localparam int REG_ADDR = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = ADDR_W'(REG_ADDR);
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic              wr_unlock = 1'b1;
    logic              cmp_out = 1'b0;
    logic              cmp_en = 1'b0;
    logic              slow_clk = 1'b0;
    logic              irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    cmp_irq_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .RUN_LEN(3)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wr_unlock (wr_unlock),
        .cmp_out   (cmp_out),
        .cmp_en    (cmp_en),
        .slow_clk  (slow_clk),
        .irq       (irq)
    );

    function automatic logic [7:0] cfg(input bit fall, input bit [1:0] dv,
                                       input bit byp, input bit ie, input bit keep);
        return {fall, 1'b0, dv, 1'b0, keep, byp, ie};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(output logic [7:0] d);
        bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            slow_clk = 1'b1;
            @(negedge clk);
            slow_clk = 1'b0;
        end
    endtask

    task automatic flag_is(input string req, input bit exp);
        logic [7:0] r;
        rd(r);
        chk(req, r[2], exp);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        step(3);
        rst_n = 1'b1;
        step(2);

        // R1 reset value
        rd(r);
        chk("R1 reset byte", r, 8'h8A);
        chk("R1 reset irq", irq, 1'b0);

        // R2 locked write and wrong address
        wr_unlock = 1'b0;
        wr(8'h31);
        rd(r);
        chk("R2 locked write ignored", r, 8'h8A);
        wr_unlock = 1'b1;
        bus_addr = ADDR_W'(REG_ADDR + 1);
        wr(8'h31);
        bus_addr = ADDR_W'(REG_ADDR);
        rd(r);
        chk("R2 other address ignored", r, 8'h8A);
        wr(8'h31);
        rd(r);
        chk("R2 unlocked write", r, 8'h39);

        // R3 reserved and read-only bits
        wr(8'h40);
        rd(r);
        chk("R3 bit6 zero bit3 read-only", r, 8'h08);

        // R4 monitor
        cmp_en = 1'b1;
        cmp_out = 1'b0;
        rd(r);
        chk("R4 monitor low", r[3], 1'b0);
        cmp_out = 1'b1;
        rd(r);
        chk("R4 monitor high", r[3], 1'b1);
        cmp_en = 1'b0;
        cmp_out = 1'b0;
        rd(r);
        chk("R4 monitor forced when off", r[3], 1'b1);
        cmp_en = 1'b1;

        // R5 / R6 bypass edge sweep
        for (int fall = 0; fall < 2; fall++) begin
            for (int dir = 0; dir < 2; dir++) begin
                @(negedge clk);
                cmp_out = (dir == 1) ? 1'b0 : 1'b1;
                step(2);
                wr(cfg(fall[0], 2'b00, 1'b1, 1'b1, 1'b0));
                flag_is("R5 flag clear before edge", 1'b0);
                cmp_out = ~cmp_out;
                flag_is("R5 no flag before clock edge", 1'b0);
                step(1);
                flag_is("R6 edge select sweep",
                        ((fall == 0) && (dir == 1)) || ((fall == 1) && (dir == 0)));
                chk("R9 irq follows flag", irq,
                    ((fall == 0) && (dir == 1)) || ((fall == 1) && (dir == 0)));
            end
        end

        // R8 write-one keeps, write-zero clears, set beats clear
        wr(cfg(1'b0, 2'b00, 1'b1, 1'b1, 1'b0));
        cmp_out = 1'b0;
        step(2);
        cmp_out = 1'b1;
        step(1);
        flag_is("R8 flag set", 1'b1);
        wr(cfg(1'b0, 2'b00, 1'b1, 1'b1, 1'b1));
        flag_is("R8 write one keeps flag", 1'b1);
        wr(cfg(1'b0, 2'b00, 1'b1, 1'b1, 1'b0));
        flag_is("R8 write zero clears flag", 1'b0);
        cmp_out = 1'b0;
        step(2);
        @(negedge clk);
        cmp_out = 1'b1;
        bus_wr = 1'b1;
        bus_wdata = cfg(1'b0, 2'b00, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        bus_wr = 1'b0;
        flag_is("R8 set wins over clear", 1'b1);

        // R9 enable / comparator-power sweep
        for (int ie = 0; ie < 2; ie++) begin
            for (int en = 0; en < 2; en++) begin
                cmp_en = 1'b1;
                cmp_out = 1'b0;
                step(2);
                wr(cfg(1'b0, 2'b00, 1'b1, ie[0], 1'b0));
                cmp_en = en[0];
                step(1);
                cmp_out = 1'b1;
                step(2);
                flag_is("R9 set needs enable and power", (ie == 1) && (en == 1));
                chk("R9 irq gating", irq, (ie == 1) && (en == 1));
            end
        end
        cmp_en = 1'b1;
        cmp_out = 1'b0;
        step(2);
        wr(cfg(1'b0, 2'b00, 1'b1, 1'b1, 1'b0));
        cmp_out = 1'b1;
        step(1);
        cmp_en = 1'b0;
        #1;
        chk("R9 irq masked while off", irq, 1'b0);
        flag_is("R9 flag kept while off", 1'b1);
        cmp_en = 1'b1;
        #1;
        chk("R9 irq back when on", irq, 1'b1);
        wr(cfg(1'b0, 2'b00, 1'b1, 1'b0, 1'b1));
        chk("R9 irq masked by enable bit", irq, 1'b0);

        // R7 filter divider sweep
        for (int d = 0; d < 4; d++) begin
            cmp_en = 1'b1;
            cmp_out = 1'b1;
            wr(cfg(1'b1, 2'b00, 1'b1, 1'b1, 1'b0));
            wr(cfg(1'b1, d[1:0], 1'b0, 1'b1, 1'b0));
            cmp_out = 1'b0;
            pulse(3 * (1 << d) - 1);
            step(2);
            flag_is("R7 no update one tick early", 1'b0);
            pulse(1);
            flag_is("R7 flag not before detector edge", 1'b0);
            step(1);
            flag_is("R7 update after three samples", 1'b1);
            chk("R7 irq after filter", irq, 1'b1);
        end

        // R11 broken run
        cmp_out = 1'b1;
        wr(cfg(1'b1, 2'b00, 1'b1, 1'b1, 1'b0));
        wr(cfg(1'b1, 2'b00, 1'b0, 1'b1, 1'b0));
        cmp_out = 1'b0;
        pulse(2);
        cmp_out = 1'b1;
        pulse(1);
        cmp_out = 1'b0;
        pulse(2);
        step(2);
        flag_is("R11 broken run not accepted", 1'b0);
        pulse(1);
        step(1);
        flag_is("R11 fresh run accepted", 1'b1);

        // R10 mode change reload
        cmp_out = 1'b1;
        wr(cfg(1'b0, 2'b00, 1'b0, 1'b1, 1'b0));
        wr(cfg(1'b0, 2'b00, 1'b1, 1'b1, 1'b0));
        step(1);
        cmp_out = 1'b0;
        step(2);
        wr(cfg(1'b0, 2'b00, 1'b1, 1'b1, 1'b0));
        flag_is("R10 flag clear before switch", 1'b0);
        wr(cfg(1'b0, 2'b00, 1'b0, 1'b1, 1'b0));
        step(3);
        flag_is("R10 no spurious edge on switch", 1'b0);
        chk("R10 irq quiet on switch", irq, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule